// File: doc/BRIEF.md
# Four-Core Power Sequencing Controller

This block sequences power for a small cluster of processor cores. Software talks to it over a zero-wait, APB-style register port. Through that port it can bring individual cores up, arm a running core to drop into standby, read the live power state of every core, and hold a set of debug reset enables. Each core has three outputs: a power switch enable, an isolation clamp and a reset hold. The controller steps these outputs through fixed-length timed sequences.

Power-up is requested by setting a bit in the wake register. That bit stays set while the sequence runs and clears itself when the core is running, so software polls the register until it reads zero. Power-down is deferred. A write to the core's control register only arms it, and the core is taken down the next time it raises its wait-for-interrupt input. The status register packs one 2-bit state code per core at a 4-bit stride.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset core 0 reads run (code 0) with power on, isolation off and reset released. All other cores read standby (code 3) with power off, isolation on and reset held. The wake, per-core control and debug registers read zero.
- R2: Writing a one to bit n of the wake register (offset 0x10) while core n is not running sets bit n. The bit reads one until core n reaches run and then reads zero. Bits written as zero have no effect.
- R3: Power-up timing. Power enable rises one cycle after the wake write takes effect. Isolation is released 16 cycles after power enable rises. Reset is released 8 cycles after isolation is released, and at the same time the core reports run.
- R4: The status register (offset 0x40) holds core n's state in bits [4n+1:4n]: 0 run, 1 powering up, 2 powering down, 3 standby. All other bits read zero, and writes to this register are ignored.
- R5: Writing 3 to core n's control register (offset 0x100 + 0x10*n) arms standby. The stored 2-bit value reads back. An armed running core keeps running until its wait-for-interrupt input is high at a clock edge.
- R6: Power-down timing. Reset is asserted in the cycle after the wait-for-interrupt edge. Isolation is applied 8 cycles later, and power enable falls 16 cycles after that, at which point the core reports standby. Reaching standby clears that core's control register to zero.
- R7: A wake request to a core that is already running leaves the wake register reading zero and the core unchanged.
- R8: The debug register (offset 0x180) is 32 bits, fully read/write. Bit 24 drives the other-core reset enable, bit 20+n drives core n's reset enable, and bit 19 drives the peripheral reset enable.
- R9: Writes to unmapped offsets, including control offsets beyond the last core, change no register. Reads from those offsets return zero.
- R10: A wake request made while a core is powering down reads back as one. The core completes standby and then powers up again, and the bit clears once the core is running.
- R11: A high wait-for-interrupt input on a core that is not armed leaves the core running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero outside reads |
| wfi | input | NCORES | Per-core wait-for-interrupt |
| core_pwr_en | output | NCORES | Power switch enable |
| core_iso | output | NCORES | Isolation clamp, 1 = isolated |
| core_rst | output | NCORES | Reset hold, 1 = held |
| dbg_other_en | output | 1 | Other-core reset request enable |
| dbg_core_en | output | NCORES | Per-core reset request enable |
| dbg_periph_en | output | 1 | Peripheral reset request enable |

## Verification
The bench uses the default build of four cores with waits of 16 and 8 cycles. With these values the full 24-cycle up and down sequences can be timed edge by edge, the first and last cycle of each phase can be compared, and the status register can be caught mid-sequence with ordinary reads. Four cores also leave control offsets beyond the last core unmapped, so the reserved-decode case can be checked. The same four cores place the per-core debug enables at bits 20 to 23, between the other-core and peripheral bits.

// File: rtl/core_pwr_seq.sv
module core_pwr_seq #(
  parameter int NCORES   = 4,
  parameter int PWR_WAIT = 16,
  parameter int ISO_WAIT = 8,
  parameter int AW       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [NCORES-1:0] wfi,
  output logic [NCORES-1:0] core_pwr_en,
  output logic [NCORES-1:0] core_iso,
  output logic [NCORES-1:0] core_rst,
  output logic              dbg_other_en,
  output logic [NCORES-1:0] dbg_core_en,
  output logic              dbg_periph_en
);
  localparam int TOTAL = PWR_WAIT + ISO_WAIT;
  localparam int CW = $clog2(TOTAL + 1);
  localparam logic [1:0] S_RUN = 2'd0, S_UP = 2'd1, S_DOWN = 2'd2, S_STBY = 2'd3;
  localparam logic [AW-1:0] A_WAKE = AW'(16'h010);
  localparam logic [AW-1:0] A_STAT = AW'(16'h040);
  localparam logic [AW-1:0] A_DBG  = AW'(16'h180);

  logic [1:0]    st   [NCORES];
  logic [1:0]    mode [NCORES];
  logic [CW-1:0] cnt  [NCORES];
  logic          req  [NCORES];
  logic [31:0]   dbg;
  logic [2*NCORES-1:0] stat_v;
  logic [NCORES-1:0]   req_v;

  wire wr      = psel & penable & pwrite;
  wire wake_wr = wr && paddr == A_WAKE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   dbg <= '0;
    else if (wr && paddr == A_DBG) dbg <= pwdata;

  assign dbg_other_en  = dbg[24];
  assign dbg_core_en   = dbg[20 +: NCORES];
  assign dbg_periph_en = dbg[19];

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    wire ctl_wr = wr && paddr == AW'(256 + 16*g);
    wire done   = cnt[g] == CW'(TOTAL - 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st[g]   <= (g == 0) ? S_RUN : S_STBY;
        mode[g] <= '0;
        cnt[g]  <= '0;
        req[g]  <= 1'b0;
      end else begin
        case (st[g])
          S_RUN: begin
            req[g] <= 1'b0;
            if (mode[g] == 2'd3 && wfi[g]) begin
              st[g]  <= S_DOWN;
              cnt[g] <= '0;
            end
          end
          S_UP: begin
            cnt[g] <= cnt[g] + 1'b1;
            if (done) st[g] <= S_RUN;
          end
          S_DOWN: begin
            cnt[g] <= cnt[g] + 1'b1;
            if (done) begin
              st[g]   <= S_STBY;
              mode[g] <= '0;
            end
          end
          default: if (req[g]) begin
            st[g]  <= S_UP;
            cnt[g] <= '0;
          end
        endcase
        if (ctl_wr) mode[g] <= pwdata[1:0];
        if (wake_wr && pwdata[g] && st[g] != S_RUN && !(st[g] == S_UP && done))
          req[g] <= 1'b1;
      end
    end

    assign core_pwr_en[g] = st[g] != S_STBY;
    assign core_rst[g]    = st[g] != S_RUN;
    assign core_iso[g]    = (st[g] == S_STBY) ||
                            (st[g] == S_UP   && cnt[g] <  CW'(PWR_WAIT)) ||
                            (st[g] == S_DOWN && cnt[g] >= CW'(ISO_WAIT));
    assign stat_v[2*g +: 2] = st[g];
    assign req_v[g]         = req[g];
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (paddr == A_WAKE) prdata[NCORES-1:0] = req_v;
      if (paddr == A_DBG)  prdata = dbg;
      if (paddr == A_STAT)
        for (int i = 0; i < NCORES; i++) prdata[4*i +: 2] = stat_v[2*i +: 2];
      for (int i = 0; i < NCORES; i++)
        if (paddr == AW'(256 + 16*i)) prdata[1:0] = mode[i];
    end
  end
endmodule

module core_pwr_seq_chk #(
  parameter int NCORES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCORES-1:0]   wfi,
  input logic [NCORES-1:0]   pwr_en,
  input logic [NCORES-1:0]   iso,
  input logic [NCORES-1:0]   crst,
  input logic [2*NCORES-1:0] stat,
  input logic [NCORES-1:0]   reqv
);
  for (genvar g = 0; g < NCORES; g++) begin : g_a
    AST_OFF_IS_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en[g] |-> iso[g] && crst[g]);  // R6
    AST_RUN_UNCLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
      !crst[g] |-> !iso[g] && pwr_en[g]);  // R3
    AST_DOWN_NEEDS_WFI: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[2*g +: 2] == 2'd0 && !wfi[g]) |=> stat[2*g +: 2] != 2'd2);  // R5
    AST_STBY_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      stat[2*g +: 2] == 2'd3 |-> !pwr_en[g] && iso[g] && crst[g]);  // R4
    AST_REQ_DROPS_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (reqv[g] && stat[2*g +: 2] == 2'd0) |=> !reqv[g]);  // R7
  end
endmodule

bind core_pwr_seq core_pwr_seq_chk #(.NCORES(NCORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wfi(wfi), .pwr_en(core_pwr_en), .iso(core_iso),
  .crst(core_rst), .stat(stat_v), .reqv(req_v)
);

// File: tb/core_pwr_seq_bench.sv
module core_pwr_seq_bench;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [N-1:0] wfi = '0, pwr_en, iso, crst, dbg_core;
  logic dbg_other, dbg_periph;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  core_pwr_seq u_core_pwr_seq (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .wfi(wfi),
    .core_pwr_en(pwr_en), .core_iso(iso), .core_rst(crst),
    .dbg_other_en(dbg_other), .dbg_core_en(dbg_core), .dbg_periph_en(dbg_periph)
  );

  // {is_write, offset, write data, expected read}
  localparam logic [76:0] VEC [14] = '{
    {1'b1, 12'h180, 32'h01F8_0000, 32'h0},
    {1'b0, 12'h180, 32'h0,         32'h01F8_0000},   // R8
    {1'b1, 12'h180, 32'hA5A5_5A5A, 32'h0},
    {1'b0, 12'h180, 32'h0,         32'hA5A5_5A5A},   // R8
    {1'b1, 12'h120, 32'h0000_0003, 32'h0},
    {1'b0, 12'h120, 32'h0,         32'h0000_0003},   // R5
    {1'b1, 12'h120, 32'h0000_0000, 32'h0},
    {1'b0, 12'h120, 32'h0,         32'h0000_0000},   // R5
    {1'b1, 12'h044, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h044, 32'h0,         32'h0},           // R9
    {1'b1, 12'h140, 32'h0000_0003, 32'h0},
    {1'b0, 12'h140, 32'h0,         32'h0},           // R9
    {1'b1, 12'h040, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h040, 32'h0,         32'h0000_3330}    // R4
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pwr_en", {28'h0, pwr_en}, 32'h1);
    chk("R1 iso", {28'h0, iso}, 32'hE);
    chk("R1 rst", {28'h0, crst}, 32'hE);
    rd(12'h010, d); chk("R1 wake", d, 0);
    rd(12'h180, d); chk("R1 dbg", d, 0);
    rd(12'h130, d); chk("R1 ctl3", d, 0);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], d);
        chk($sformatf("R4/R5/R8/R9 vector %0d", i), d, VEC[i][31:0]);
      end
    end

    wr(12'h180, 32'h0128_0000);
    chk("R8 other", {31'h0, dbg_other}, 1);
    chk("R8 core", {28'h0, dbg_core}, 32'h2);
    chk("R8 periph", {31'h0, dbg_periph}, 1);
    wr(12'h180, 32'h0008_0000);
    chk("R8 periph only", {29'h0, dbg_other, dbg_periph, dbg_core[1]}, 32'h2);

    // R7: wake to running core 0
    wr(12'h010, 32'h1);
    rd(12'h010, d); chk("R7 wake", d, 0);
    rd(12'h040, d); chk("R7 status", d, 32'h3330);

    // R11: wfi without arm
    wfi[0] = 1; wait_n(5); wfi[0] = 0;
    rd(12'h040, d); chk("R11 status", d, 32'h3330);
    chk("R11 rst", {31'h0, crst[0]}, 0);

    // R2/R3: power-up timing of core 1; write edge E, return at E+0.5
    wr(12'h010, 32'h2);
    chk("R3 pwr_en before", {31'h0, pwr_en[1]}, 0);
    wait_n(1);
    chk("R3 pwr_en", {29'h0, pwr_en[1], iso[1], crst[1]}, 32'h7);
    wait_n(15); chk("R3 iso held", {31'h0, iso[1]}, 1);
    wait_n(1);  chk("R3 iso released", {30'h0, iso[1], crst[1]}, 32'h1);
    wait_n(7);  chk("R3 rst held", {31'h0, crst[1]}, 1);
    wait_n(1);  chk("R3 rst released", {31'h0, crst[1]}, 0);
    rd(12'h010, d); chk("R2 wake cleared", d, 0);
    rd(12'h040, d); chk("R4 status core1 run", d, 32'h3300);

    // R2/R4: reads mid-sequence on core 2
    wr(12'h010, 32'h4);
    rd(12'h010, d); chk("R2 wake pending", d, 32'h4);
    rd(12'h040, d); chk("R4 powering up", d, 32'h3100);
    wait_n(30);
    rd(12'h010, d); chk("R2 wake done", d, 0);
    rd(12'h040, d); chk("R4 status", d, 32'h3000);

    // R5/R6: arm and take down core 1
    wr(12'h110, 32'h3);
    wait_n(5);
    rd(12'h040, d); chk("R5 armed still run", d, 32'h3000);
    chk("R5 pwr", {31'h0, pwr_en[1]}, 1);
    wfi[1] = 1;
    @(negedge clk); wfi[1] = 0;
    chk("R6 rst asserted", {29'h0, pwr_en[1], iso[1], crst[1]}, 32'h5);
    wait_n(7);  chk("R6 iso before", {31'h0, iso[1]}, 0);
    wait_n(1);  chk("R6 iso applied", {31'h0, iso[1]}, 1);
    wait_n(15); chk("R6 pwr before", {31'h0, pwr_en[1]}, 1);
    wait_n(1);  chk("R6 pwr off", {31'h0, pwr_en[1]}, 0);
    rd(12'h040, d); chk("R6 standby", d, 32'h3030);
    rd(12'h110, d); chk("R6 arm cleared", d, 0);

    // R10: wake during power-down of core 2
    wr(12'h120, 32'h3);
    wfi[2] = 1;
    @(negedge clk); wfi[2] = 0;
    wr(12'h010, 32'h4);
    rd(12'h010, d); chk("R10 pending", d, 32'h4);
    rd(12'h040, d); chk("R10 down", d, 32'h3230);
    for (int k = 0; k < 100; k++) begin
      rd(12'h010, d);
      if (d == 0) break;
    end
    chk("R10 wake cleared", d, 0);
    rd(12'h040, d); chk("R10 running again", d, 32'h3030);
    rd(12'h120, d); chk("R10 arm cleared", d, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule